// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing core of a two-output pulse-width modulator. A two-stage prescaler divides the system clock into count steps. A 16-bit counter advances on each step. Depending on the selected scheme, the counter counts up, counts down, counts up then down, or holds its value. A control word selects the counting scheme, the prescale factor, how new period values take effect and how the counter stops. The period value is written through the same single-cycle write port.

The block has four outputs for the downstream action logic: the current count, a direction flag, and two event strobes. One strobe marks the count reaching zero. The other marks the count reaching the active period. Each strobe lasts one system-clock cycle and only appears on a count step. A period value written in shadow mode takes effect at the next arrival at zero. A value written in immediate mode takes effect at once. The counter can stop after its next step, or at the end of the running cycle, or it can run freely. A stopped or frozen counter keeps its value and resumes from that value.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction flag is 1, both strobes are 0 and the counter is stopped. It does not move until a control word with bit 15 set is written.
- R2: Counter mode field bits 1:0 = 00 counts up. Each step adds one, except that a count at or above the active period returns to 0. The direction flag is 1 after every step.
- R3: Mode 01 counts down. Each step subtracts one, except that a count of 0 reloads the active period. The direction flag is 0 after every step.
- R4: Mode 10 counts up then down. While rising, a count at or above the period turns the direction to down and decrements. While falling, a count of 0 turns the direction to up and increments. The direction flag shows the current direction.
- R5: With coarse field c = control bits 12:10 and fine field f = bits 9:7, a step occurs every F = 2^c × (f = 0 ? 1 : 2f) system-clock cycles. The first step comes F cycles after the control write. No step happens in the cycle of a control write.
- R6: The zero strobe (zero_evt_o) is high for the one cycle in which a step has just made the count 0. The period strobe (prd_evt_o) is high for the one cycle in which a step has just made the count equal the period in use. Neither strobe is high in any other cycle.
- R7: Mode 11 freezes the count and the direction flag. Writing a counting mode with free-run continues from the held value.
- R8: Run field bits 15:14 control stopping. 00 stops the counter after exactly one more step. 01 stops it on the step that brings the count to 0. 11 and 10 run freely. A stopped count holds and resumes from its value.
- R9: With control bit 3 = 0, a period write goes to a shadow copy. The shadow copy becomes the active period on the step that brings the count to 0.
- R10: With control bit 3 = 1, a period write replaces the active period at once.
- R11: The period is 16 bits wide. A period of 0xFFFF in up mode reaches 0xFFFF and raises the period strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control word, 1 period |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current count |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |
| zero_evt_o | output | 1 | Zero-match strobe |
| prd_evt_o | output | 1 | Period-match strobe |

## Verification
Each of the three counting schemes is run from reset for a chosen number of steps. The stopping points are set just before, at, and just after the wrap or reversal, so an off-by-one turning point or a wrong direction flag shows up. The same up-count is repeated with several coarse/fine prescaler pairs, including the largest one. Separate tests check the count one cycle before and on the expected step, which would expose a wrong factor formula or swapped fields. Directed sequences then freeze, stop-next and stop-at-end the counter and resume it. They also write a smaller period in shadow and in immediate mode: the peak count before the next zero shows which period was in use.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_STOP_NEXT = 2'b00,
        RUN_STOP_END  = 2'b01,
        RUN_FREE_ALT  = 2'b10,
        RUN_FREE      = 2'b11
    } run_mode_e;

    localparam int COARSE_W = 3;
    localparam int FINE_W   = 3;

    // control word field positions
    localparam int CTL_MODE_LSB   = 0;
    localparam int CTL_IMM_BIT    = 3;
    localparam int CTL_FINE_LSB   = 7;
    localparam int CTL_COARSE_LSB = 10;
    localparam int CTL_RUN_LSB    = 14;

    typedef struct packed {
        run_mode_e             run;
        logic [COARSE_W-1:0]   coarse;
        logic [FINE_W-1:0]     fine;
        logic                  prd_imm;
        cnt_mode_e             mode;
    } ctl_state_t;

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
    parameter int POW_W = 3,
    parameter int LIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic [POW_W-1:0] pow_sel,
    input  logic [LIN_W-1:0] lin_sel,
    output logic             tick
);
    localparam int S1_W = (1 << POW_W) - 1;
    localparam int S1_E = S1_W + 1;
    localparam int S2_W = LIN_W + 1;

    typedef struct packed {
        logic [S1_W-1:0] s1;
        logic [S2_W-1:0] s2;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [S1_W:0]   pow_one;
    logic [S1_W-1:0] lim1;
    logic [S2_W-1:0] lim2;
    logic            s1_end, s2_end;

    always_comb begin
        pow_one = S1_E'(1) << pow_sel;
        lim1    = S1_W'(pow_one - S1_E'(1));
        lim2    = (lin_sel == '0) ? '0 : ({lin_sel, 1'b0} - S2_W'(1));
        s1_end  = (st_q.s1 == lim1);
        s2_end  = (st_q.s2 == lim2);
        tick    = enable && !clear && s1_end && s2_end;

        st_d = st_q;
        if (clear || !enable) begin
            st_d = '0;
        end else if (s1_end) begin
            st_d.s1 = '0;
            st_d.s2 = s2_end ? '0 : st_q.s2 + S2_W'(1);
        end else begin
            st_d.s1 = st_q.s1 + S1_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_data,
    input  logic             imm,
    input  logic             reload,
    output logic [CNT_W-1:0] prd_active
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } prd_state_t;

    prd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prd_wr) st_d.shadow = prd_data;
        if (prd_wr && imm)         st_d.active = prd_data;
        else if (reload && !imm)   st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prd_active = st_q.active;

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             start,
    input  cnt_mode_e        mode,
    input  run_mode_e        run,
    input  logic [CNT_W-1:0] prd,
    output logic             running,
    output logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             zero_evt,
    output logic             prd_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
        logic             stopped;
        logic             zero_evt;
        logic             prd_evt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_dir;

    always_comb begin
        nxt_cnt = st_q.cnt;
        nxt_dir = st_q.dir_up;
        unique case (mode)
            CM_UP: begin
                nxt_dir = 1'b1;
                nxt_cnt = (st_q.cnt >= prd) ? '0 : st_q.cnt + CNT_W'(1);
            end
            CM_DOWN: begin
                nxt_dir = 1'b0;
                nxt_cnt = (st_q.cnt == '0) ? prd : st_q.cnt - CNT_W'(1);
            end
            CM_UPDN: begin
                if (st_q.dir_up) begin
                    if (st_q.cnt >= prd) begin
                        nxt_dir = 1'b0;
                        nxt_cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
                    end else begin
                        nxt_cnt = st_q.cnt + CNT_W'(1);
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        nxt_dir = 1'b1;
                        nxt_cnt = (prd == '0) ? '0 : CNT_W'(1);
                    end else begin
                        nxt_cnt = st_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: begin
                nxt_cnt = st_q.cnt;
                nxt_dir = st_q.dir_up;
            end
        endcase

        running = !st_q.stopped && (mode != CM_HOLD);
        reload  = step && (nxt_cnt == '0);

        st_d          = st_q;
        st_d.zero_evt = step && (nxt_cnt == '0);
        st_d.prd_evt  = step && (nxt_cnt == prd);
        if (step) begin
            st_d.cnt    = nxt_cnt;
            st_d.dir_up = nxt_dir;
        end

        if (start) begin
            st_d.stopped = 1'b0;
        end else if (step) begin
            unique case (run)
                RUN_STOP_NEXT: st_d.stopped = 1'b1;
                RUN_STOP_END:  st_d.stopped = (nxt_cnt == '0);
                default:       st_d.stopped = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.dir_up   <= 1'b1;
            st_q.stopped  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign dir_up   = st_q.dir_up;
    assign zero_evt = st_q.zero_evt;
    assign prd_evt  = st_q.prd_evt;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_up_o,
    output logic             zero_evt_o,
    output logic             prd_evt_o
);
    ctl_state_t       ctl_d, ctl_q;
    logic             ctl_wr, prd_wr, run_start;
    logic             step_tick, cnt_running, zero_reload;
    logic [CNT_W-1:0] prd_active;

    always_comb begin
        ctl_wr    = wr_en && !wr_sel;
        prd_wr    = wr_en && wr_sel;
        run_start = ctl_wr && wr_data[CTL_RUN_LSB+1];
        ctl_d     = ctl_q;
        if (ctl_wr) begin
            ctl_d.run     = run_mode_e'(wr_data[CTL_RUN_LSB +: 2]);
            ctl_d.coarse  = wr_data[CTL_COARSE_LSB +: COARSE_W];
            ctl_d.fine    = wr_data[CTL_FINE_LSB +: FINE_W];
            ctl_d.prd_imm = wr_data[CTL_IMM_BIT];
            ctl_d.mode    = cnt_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pwm_tb_prescale #(
        .POW_W (COARSE_W),
        .LIN_W (FINE_W)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cnt_running),
        .clear   (ctl_wr),
        .pow_sel (ctl_q.coarse),
        .lin_sel (ctl_q.fine),
        .tick    (step_tick)
    );

    pwm_tb_period #(
        .CNT_W (CNT_W)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .prd_wr     (prd_wr),
        .prd_data   (wr_data),
        .imm        (ctl_q.prd_imm),
        .reload     (zero_reload),
        .prd_active (prd_active)
    );

    pwm_tb_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_tick),
        .start    (run_start),
        .mode     (ctl_q.mode),
        .run      (ctl_q.run),
        .prd      (prd_active),
        .running  (cnt_running),
        .reload   (zero_reload),
        .cnt      (cnt_o),
        .dir_up   (dir_up_o),
        .zero_evt (zero_evt_o),
        .prd_evt  (prd_evt_o)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic             running,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] cnt,
    input logic             dir_up,
    input logic             zero_evt,
    input logic             prd_evt,
    input logic [CNT_W-1:0] prd_active
);
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt)); // R5

    AST_ZERO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (cnt == '0)); // R6

    AST_PRD_AT_PRD: assert property (@(posedge clk) disable iff (!rst_n)
        prd_evt |-> (cnt == $past(prd_active))); // R6

    AST_ZERO_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> $past(step)); // R6

    AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == 2'b00) |=> dir_up); // R2

    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == 2'b01) |=> !dir_up); // R3

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> ($stable(cnt) && $stable(dir_up))); // R8

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step_tick),
    .running    (cnt_running),
    .mode       (ctl_q.mode),
    .cnt        (cnt_o),
    .dir_up     (dir_up_o),
    .zero_evt   (zero_evt_o),
    .prd_evt    (prd_evt_o),
    .prd_active (prd_active)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic        dir_up_o, zero_evt_o, prd_evt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .cnt_o      (cnt_o),
        .dir_up_o   (dir_up_o),
        .zero_evt_o (zero_evt_o),
        .prd_evt_o  (prd_evt_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  pw;
        logic [2:0]  ln;
        logic [15:0] prd;
        logic [16:0] steps;
        logic [15:0] ecnt;
        logic        edir;
        logic        ezero;
        logic        eprd;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 3'd0, 3'd0, 16'd5,      17'd3,     16'd3,      1'b1, 1'b0, 1'b0}, // R2
        '{2'b00, 3'd0, 3'd0, 16'd5,      17'd6,     16'd0,      1'b1, 1'b1, 1'b0}, // R2
        '{2'b00, 3'd0, 3'd0, 16'd5,      17'd8,     16'd2,      1'b1, 1'b0, 1'b0}, // R2
        '{2'b01, 3'd0, 3'd0, 16'd4,      17'd1,     16'd4,      1'b0, 1'b0, 1'b1}, // R3
        '{2'b01, 3'd0, 3'd0, 16'd4,      17'd5,     16'd0,      1'b0, 1'b1, 1'b0}, // R3
        '{2'b10, 3'd0, 3'd0, 16'd3,      17'd3,     16'd3,      1'b1, 1'b0, 1'b1}, // R4
        '{2'b10, 3'd0, 3'd0, 16'd3,      17'd4,     16'd2,      1'b0, 1'b0, 1'b0}, // R4
        '{2'b10, 3'd0, 3'd0, 16'd3,      17'd7,     16'd1,      1'b1, 1'b0, 1'b0}, // R4
        '{2'b00, 3'd2, 3'd3, 16'd10,     17'd4,     16'd4,      1'b1, 1'b0, 1'b0}, // R5
        '{2'b00, 3'd0, 3'd1, 16'd10,     17'd7,     16'd7,      1'b1, 1'b0, 1'b0}, // R5
        '{2'b00, 3'd7, 3'd7, 16'd100,    17'd2,     16'd2,      1'b1, 1'b0, 1'b0}, // R5
        '{2'b00, 3'd3, 3'd0, 16'd3,      17'd4,     16'd0,      1'b1, 1'b1, 1'b0}, // R5
        '{2'b00, 3'd0, 3'd0, 16'hFFFF,   17'hFFFF,  16'hFFFF,   1'b1, 1'b0, 1'b1}, // R11
        '{2'b01, 3'd1, 3'd2, 16'd6,      17'd2,     16'd5,      1'b0, 1'b0, 1'b0}  // R3
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1, 2:        return "R2";
            3, 4, 13:       return "R3";
            5, 6, 7:        return "R4";
            8, 9, 10, 11:   return "R5";
            default:        return "R11";
        endcase
    endfunction

    function automatic int factor(input logic [2:0] pw, input logic [2:0] ln);
        return (1 << pw) * ((ln == 3'd0) ? 1 : 2 * int'(ln));
    endfunction

    function automatic logic [15:0] mk_ctl(input logic [1:0] run, input logic imm,
                                           input logic [1:0] mode,
                                           input logic [2:0] pw, input logic [2:0] ln);
        return {run, 1'b0, pw, ln, 3'b000, imm, 1'b0, mode};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reset, load period immediately while stopped, then start free-run
    task automatic setup(input logic [1:0] mode, input logic [2:0] pw, input logic [2:0] ln,
                         input logic [15:0] prd, input logic imm_run);
        do_reset();
        wr(1'b0, mk_ctl(2'b00, 1'b1, mode, pw, ln));
        wr(1'b1, prd);
        wr(1'b0, mk_ctl(2'b11, imm_run, mode, pw, ln));
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 cnt", 32'(cnt_o), 32'd0);
        chk("R1 dir", 32'(dir_up_o), 32'd1);
        chk("R1 strobes", 32'({zero_evt_o, prd_evt_o}), 32'd0);
        wr(1'b0, mk_ctl(2'b00, 1'b1, 2'b00, 3'd0, 3'd0));
        wr(1'b1, 16'd5);
        wait_cyc(10);
        chk("R1 stays stopped", 32'(cnt_o), 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            setup(VECS[i].mode, VECS[i].pw, VECS[i].ln, VECS[i].prd, 1'b1);
            wait_cyc(int'(VECS[i].steps) * factor(VECS[i].pw, VECS[i].ln));
            chk({row_req(i), " cnt"},  32'(cnt_o),      32'(VECS[i].ecnt));
            chk({row_req(i), " dir"},  32'(dir_up_o),   32'(VECS[i].edir));
            chk({row_req(i), " zero"}, 32'(zero_evt_o), 32'(VECS[i].ezero));
            chk({row_req(i), " prd"},  32'(prd_evt_o),  32'(VECS[i].eprd));
        end

        // R5: step lands exactly F=24 cycles after the start write
        setup(2'b00, 3'd2, 3'd3, 16'd10, 1'b1);
        wait_cyc(23);
        chk("R5 before step", 32'(cnt_o), 32'd0);
        wait_cyc(1);
        chk("R5 on step", 32'(cnt_o), 32'd1);

        // R6: strobe width with F=4, period 2
        setup(2'b00, 3'd2, 3'd0, 16'd2, 1'b1);
        wait_cyc(8);
        chk("R6 prd strobe", 32'({cnt_o, prd_evt_o}), 32'({16'd2, 1'b1}));
        wait_cyc(1);
        chk("R6 prd strobe one cycle", 32'({prd_evt_o, zero_evt_o}), 32'd0);
        wait_cyc(3);
        chk("R6 zero strobe", 32'({cnt_o, zero_evt_o}), 32'({16'd0, 1'b1}));
        wait_cyc(1);
        chk("R6 zero strobe one cycle", 32'(zero_evt_o), 32'd0);

        // R7: freeze and resume
        setup(2'b00, 3'd0, 3'd0, 16'd50, 1'b1);
        wait_cyc(5);
        chk("R7 pre-freeze", 32'(cnt_o), 32'd5);
        wr(1'b0, mk_ctl(2'b11, 1'b1, 2'b11, 3'd0, 3'd0));
        wait_cyc(10);
        chk("R7 frozen", 32'({cnt_o, dir_up_o}), 32'({16'd5, 1'b1}));
        wr(1'b0, mk_ctl(2'b11, 1'b1, 2'b00, 3'd0, 3'd0));
        wait_cyc(1);
        chk("R7 resume", 32'(cnt_o), 32'd6);

        // R8: stop after next step, then resume
        wr(1'b0, mk_ctl(2'b00, 1'b1, 2'b00, 3'd0, 3'd0));
        chk("R8 no step on write", 32'(cnt_o), 32'd6);
        wait_cyc(1);
        chk("R8 one more step", 32'(cnt_o), 32'd7);
        wait_cyc(10);
        chk("R8 stopped holds", 32'(cnt_o), 32'd7);
        wr(1'b0, mk_ctl(2'b11, 1'b1, 2'b00, 3'd0, 3'd0));
        wait_cyc(1);
        chk("R8 resume after stop", 32'(cnt_o), 32'd8);

        // R8: stop at end of cycle, then alternate free-run code
        setup(2'b00, 3'd0, 3'd0, 16'd5, 1'b1);
        wait_cyc(2);
        wr(1'b0, mk_ctl(2'b01, 1'b1, 2'b00, 3'd0, 3'd0));
        wait_cyc(1);
        chk("R8 end-stop keeps counting", 32'(cnt_o), 32'd3);
        wait_cyc(20);
        chk("R8 end-stop at zero", 32'(cnt_o), 32'd0);
        wr(1'b0, mk_ctl(2'b10, 1'b1, 2'b00, 3'd0, 3'd0));
        wait_cyc(3);
        chk("R8 run code 10 free", 32'(cnt_o), 32'd3);

        // R9: shadow load takes effect at zero
        begin
            bit seen_zero = 1'b0;
            int max1 = 0;
            int max2 = 0;
            setup(2'b00, 3'd0, 3'd0, 16'd5, 1'b0);
            wait_cyc(1);
            wr(1'b1, 16'd2);
            for (int k = 0; k < 12; k++) begin
                if (cnt_o == 16'd0) seen_zero = 1'b1;
                else if (!seen_zero) max1 = (int'(cnt_o) > max1) ? int'(cnt_o) : max1;
                else max2 = (int'(cnt_o) > max2) ? int'(cnt_o) : max2;
                wait_cyc(1);
            end
            chk("R9 old period until zero", 32'(max1), 32'd5);
            chk("R9 new period after zero", 32'(max2), 32'd2);
        end

        // R10: immediate load
        begin
            bit seen_zero = 1'b0;
            int max1 = 0;
            int max2 = 0;
            setup(2'b00, 3'd0, 3'd0, 16'd5, 1'b1);
            wait_cyc(1);
            wr(1'b1, 16'd3);
            for (int k = 0; k < 12; k++) begin
                if (cnt_o == 16'd0) seen_zero = 1'b1;
                else if (!seen_zero) max1 = (int'(cnt_o) > max1) ? int'(cnt_o) : max1;
                else max2 = (int'(cnt_o) > max2) ? int'(cnt_o) : max2;
                wait_cyc(1);
            end
            chk("R10 new period at once", 32'(max1), 32'd3);
            chk("R10 new period kept", 32'(max2), 32'd3);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule